// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block sits between a byte-wide, two-address register port and the priority resolver of an eight-input interrupt controller. Software talks to the controller only through byte writes and reads on this port. The decoder turns each byte into register updates and short strobes for the resolver. The resolver itself is not part of this block.

Address 0 carries three kinds of commands. The first is an initialization start. The second is a read and poll setup command. The third is the run-time operation command, which covers the end-of-interrupt forms, priority rotation and setting the lowest-priority line. Address 1 carries the mask byte during normal operation and the follow-on bytes while an initialization is in progress. The number of follow-on bytes depends on a flag in the start byte.

The decoder holds the mask, the rotation offset, the vector base and the mode bits, and drives them to the resolver. It pulses one-hot clear strobes for in-service and request bits. Read data is taken from the request, in-service or mask vectors, or from a poll result.

Top module: `irq_cmd_decoder`

## Requirements
- R1: A write to address 0 with bit 4 set, bit 3 clear and bit 1 clear starts initialization. The next cycle shows mask 0, rotation offset 0, and nested, auto-EOI, rotate-on-auto-EOI and special-mask modes all cleared. Read select returns to the request vector and poll is disarmed. `ctl_reset_o` pulses for one cycle and `init_busy_o` is high. Bit 0 of the start byte records whether a mode byte will follow.
- R2: While initialization is in progress, each write to address 1 advances the sequence. The first such byte sets `vec_base_o` to its bits 7:3 with bits 2:0 zero. The second byte is accepted and discarded. After the second byte, `init_busy_o` drops the next cycle when no mode byte is expected.
- R3: When a mode byte is expected, the third address-1 write sets the nested mode from bit 4 and auto-EOI from bit 1, and ends initialization.
- R4: An operation command with bits 7:5 = 1 is a non-specific EOI. It pulses `svc_clr_o` at the highest-priority set line of `svc_vec`. Priority is counted upward from the rotation offset, so the line equal to the offset ranks highest. When no line is set, no bit pulses.
- R5: Bits 7:5 = 5 is a non-specific EOI with rotate. It behaves as in R4 and also sets the offset to the cleared line plus 1, modulo 8. When no line is set, the offset is unchanged.
- R6: Bits 7:5 = 3 pulses `svc_clr_o` at line bits 2:0. Bits 7:5 = 6 sets the offset to bits 2:0 plus 1, modulo 8. Bits 7:5 = 7 does both.
- R7: Bits 7:5 = 4 sets rotate-on-auto-EOI, and bits 7:5 = 0 clears it.
- R8: A write to address 0 with bit 4 clear and bit 3 set is a read/poll command. Its bits act as follows:
  - Bit 1 enables bit 0 to select the in-service vector (1) or the request vector (0) for address-0 reads.
  - Bit 6 enables bit 5 to load the special mask mode.
  - Bit 2 arms poll.
  - A field whose enable bit is clear is left unchanged.
- R9: Without an armed poll, a read of address 1 returns the mask. A read of address 0 returns the selected vector in the same cycle.
- R10: With poll armed, the next read at either address returns the pending line number, or 7 when nothing is pending. The cycle after that read, `req_clr_o` and `svc_clr_o` pulse at the returned line (only when something was pending), and poll is disarmed.
- R11: Outside initialization, a write to address 1 loads the mask.
- R12: A start byte with bit 1 or bit 3 set pulses `init_err_o` the next cycle and changes nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe |
| bus_addr | input | 1 | Register address |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid during the read cycle |
| req_vec | input | 8 | Request vector from the resolver |
| svc_vec | input | 8 | In-service vector from the resolver |
| pend_valid | input | 1 | Resolver has a pending line |
| pend_line | input | 3 | Pending line number |
| mask_o | output | 8 | Mask vector |
| rot_base_o | output | 3 | Rotation offset (highest-priority line) |
| vec_base_o | output | 8 | Vector base |
| nested_mode_o | output | 1 | Special nested mode |
| auto_eoi_o | output | 1 | Automatic EOI mode |
| rotate_aeoi_o | output | 1 | Rotate on automatic EOI |
| special_mask_o | output | 1 | Special mask mode |
| svc_clr_o | output | 8 | One-cycle in-service clear strobe |
| req_clr_o | output | 8 | One-cycle request clear strobe |
| ctl_reset_o | output | 1 | One-cycle resolver reset at initialization start |
| init_busy_o | output | 1 | Initialization sequence in progress |
| init_err_o | output | 1 | One-cycle flag for an unsupported start byte |

## Verification
Every register output and every strobe that a write or a poll read causes is due one cycle after the clock edge that accepts the access. Read data is combinational and is due in the cycle of the read itself. The bench drives each access from the falling edge. It samples `bus_rdata` a quarter period later, before the accepting edge. It samples registered outputs and strobes just after that edge, before the next one, so each one-cycle pulse is caught in its only valid cycle.

// File: rtl/icd_pkg.sv
package icd_pkg;
    typedef enum logic [1:0] {
        STEP_IDLE = 2'd0,
        STEP_BASE = 2'd1,
        STEP_CASC = 2'd2,
        STEP_MODE = 2'd3
    } init_step_e;

    localparam logic [2:0] OP_ROT_OFF  = 3'd0;
    localparam logic [2:0] OP_EOI_ANY  = 3'd1;
    localparam logic [2:0] OP_EOI_LINE = 3'd3;
    localparam logic [2:0] OP_ROT_ON   = 3'd4;
    localparam logic [2:0] OP_EOI_ROT  = 3'd5;
    localparam logic [2:0] OP_SET_PRI  = 3'd6;
    localparam logic [2:0] OP_LINE_ROT = 3'd7;

    localparam int BIT_START = 4;
    localparam int BIT_OCW3  = 3;
endpackage

// File: rtl/icd_prio_scan.sv
module icd_prio_scan #(
    parameter int N_LINES = 8,
    localparam int LINE_W = $clog2(N_LINES)
) (
    input  logic [N_LINES-1:0] vec,
    input  logic [LINE_W-1:0]  base,
    output logic               found,
    output logic [LINE_W-1:0]  line
);
    logic [N_LINES-1:0] rot;
    logic [LINE_W-1:0]  off;

    // rot[k] is the line k places below the base in priority
    for (genvar g = 0; g < N_LINES; g++) begin : g_rot
        assign rot[g] = vec[LINE_W'(g) + base];
    end

    always_comb begin
        found = |rot;
        off   = '0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (rot[i]) off = LINE_W'(i);
        end
        line = off + base;
    end
endmodule

// File: rtl/icd_read_mux.sv
module icd_read_mux #(
    parameter int N_LINES = 8,
    parameter int DATA_W  = 8,
    localparam int LINE_W = $clog2(N_LINES)
) (
    input  logic               rd_addr,
    input  logic               sel_isr,
    input  logic               poll_mode,
    input  logic               poll_valid,
    input  logic [LINE_W-1:0]  poll_line,
    input  logic [N_LINES-1:0] req_vec,
    input  logic [N_LINES-1:0] svc_vec,
    input  logic [N_LINES-1:0] mask,
    output logic [DATA_W-1:0]  rdata
);
    logic [DATA_W-1:0] poll_word;

    assign poll_word = poll_valid ? DATA_W'(poll_line) : DATA_W'(7);

    always_comb begin
        if (poll_mode)     rdata = poll_word;
        else if (rd_addr)  rdata = DATA_W'(mask);
        else if (sel_isr)  rdata = DATA_W'(svc_vec);
        else               rdata = DATA_W'(req_vec);
    end
endmodule

// File: rtl/irq_cmd_decoder.sv
module irq_cmd_decoder #(
    parameter int N_LINES = 8,
    parameter int DATA_W  = 8,
    localparam int LINE_W = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic               bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [N_LINES-1:0] req_vec,
    input  logic [N_LINES-1:0] svc_vec,
    input  logic               pend_valid,
    input  logic [LINE_W-1:0]  pend_line,
    output logic [N_LINES-1:0] mask_o,
    output logic [LINE_W-1:0]  rot_base_o,
    output logic [DATA_W-1:0]  vec_base_o,
    output logic               nested_mode_o,
    output logic               auto_eoi_o,
    output logic               rotate_aeoi_o,
    output logic               special_mask_o,
    output logic [N_LINES-1:0] svc_clr_o,
    output logic [N_LINES-1:0] req_clr_o,
    output logic               ctl_reset_o,
    output logic               init_busy_o,
    output logic               init_err_o
);
    import icd_pkg::*;

    typedef struct packed {
        logic [N_LINES-1:0] mask;
        logic [LINE_W-1:0]  rot_base;
        logic [DATA_W-1:0]  vec_base;
        logic               nested;
        logic               aeoi;
        logic               rot_aeoi;
        logic               smm;
        logic               sel_isr;
        logic               poll;
        logic               need_mode;
        init_step_e         step;
        logic [N_LINES-1:0] svc_clr;
        logic [N_LINES-1:0] req_clr;
        logic               ctl_reset;
        logic               err;
    } ctl_t;

    ctl_t s_d, s_q;

    logic              wr0, wr1, is_start, start_bad;
    logic [2:0]        op_code;
    logic [LINE_W-1:0] cmd_line;
    logic              hi_found;
    logic [LINE_W-1:0] hi_line;

    assign wr0       = bus_wr && !bus_addr;
    assign wr1       = bus_wr &&  bus_addr;
    assign is_start  = bus_wdata[BIT_START];
    assign start_bad = bus_wdata[1] || bus_wdata[3];
    assign op_code   = bus_wdata[7:5];
    assign cmd_line  = bus_wdata[LINE_W-1:0];

    icd_prio_scan #(.N_LINES(N_LINES)) i_isr_scan (
        .vec   (svc_vec),
        .base  (s_q.rot_base),
        .found (hi_found),
        .line  (hi_line)
    );

    icd_read_mux #(.N_LINES(N_LINES), .DATA_W(DATA_W)) i_rd_mux (
        .rd_addr    (bus_addr),
        .sel_isr    (s_q.sel_isr),
        .poll_mode  (s_q.poll),
        .poll_valid (pend_valid),
        .poll_line  (pend_line),
        .req_vec    (req_vec),
        .svc_vec    (svc_vec),
        .mask       (s_q.mask),
        .rdata      (bus_rdata)
    );

    always_comb begin
        s_d           = s_q;
        s_d.svc_clr   = '0;
        s_d.req_clr   = '0;
        s_d.ctl_reset = 1'b0;
        s_d.err       = 1'b0;

        if (wr0) begin
            if (is_start) begin
                if (start_bad) begin
                    s_d.err = 1'b1;
                end else begin
                    s_d.mask      = '0;
                    s_d.rot_base  = '0;
                    s_d.nested    = 1'b0;
                    s_d.aeoi      = 1'b0;
                    s_d.rot_aeoi  = 1'b0;
                    s_d.smm       = 1'b0;
                    s_d.sel_isr   = 1'b0;
                    s_d.poll      = 1'b0;
                    s_d.need_mode = bus_wdata[0];
                    s_d.step      = STEP_BASE;
                    s_d.ctl_reset = 1'b1;
                end
            end else if (bus_wdata[BIT_OCW3]) begin
                s_d.poll = bus_wdata[2];
                if (bus_wdata[1]) s_d.sel_isr = bus_wdata[0];
                if (bus_wdata[6]) s_d.smm     = bus_wdata[5];
            end else begin
                case (op_code)
                    OP_ROT_OFF: s_d.rot_aeoi = 1'b0;
                    OP_ROT_ON:  s_d.rot_aeoi = 1'b1;
                    OP_EOI_ANY, OP_EOI_ROT: begin
                        if (hi_found) begin
                            s_d.svc_clr = N_LINES'(1) << hi_line;
                            if (op_code == OP_EOI_ROT) s_d.rot_base = hi_line + 1'b1;
                        end
                    end
                    OP_EOI_LINE: s_d.svc_clr  = N_LINES'(1) << cmd_line;
                    OP_SET_PRI:  s_d.rot_base = cmd_line + 1'b1;
                    OP_LINE_ROT: begin
                        s_d.svc_clr  = N_LINES'(1) << cmd_line;
                        s_d.rot_base = cmd_line + 1'b1;
                    end
                    default: ;
                endcase
            end
        end else if (wr1) begin
            case (s_q.step)
                STEP_IDLE: s_d.mask = N_LINES'(bus_wdata);
                STEP_BASE: begin
                    s_d.vec_base = {bus_wdata[DATA_W-1:3], 3'b000};
                    s_d.step     = STEP_CASC;
                end
                STEP_CASC: s_d.step = s_q.need_mode ? STEP_MODE : STEP_IDLE;
                STEP_MODE: begin
                    s_d.nested = bus_wdata[4];
                    s_d.aeoi   = bus_wdata[1];
                    s_d.step   = STEP_IDLE;
                end
                default: s_d.step = STEP_IDLE;
            endcase
        end

        if (bus_rd && s_q.poll) begin
            s_d.poll = 1'b0;
            if (pend_valid) begin
                s_d.req_clr = N_LINES'(1) << pend_line;
                s_d.svc_clr = s_d.svc_clr | (N_LINES'(1) << pend_line);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mask_o         = s_q.mask;
    assign rot_base_o     = s_q.rot_base;
    assign vec_base_o     = s_q.vec_base;
    assign nested_mode_o  = s_q.nested;
    assign auto_eoi_o     = s_q.aeoi;
    assign rotate_aeoi_o  = s_q.rot_aeoi;
    assign special_mask_o = s_q.smm;
    assign svc_clr_o      = s_q.svc_clr;
    assign req_clr_o      = s_q.req_clr;
    assign ctl_reset_o    = s_q.ctl_reset;
    assign init_busy_o    = (s_q.step != STEP_IDLE);
    assign init_err_o     = s_q.err;

    assert_init_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr0 && bus_wdata[4] && !bus_wdata[3] && !bus_wdata[1])
        |=> (mask_o == '0 && rot_base_o == '0 && init_busy_o && ctl_reset_o));

    assert_busy_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr1 && s_q.step == STEP_CASC && !s_q.need_mode) |=> !init_busy_o);

    assert_mode_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr1 && s_q.step == STEP_MODE)
        |=> (nested_mode_o == $past(bus_wdata[4]) && auto_eoi_o == $past(bus_wdata[1]) && !init_busy_o));

    assert_clr_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(svc_clr_o));

    assert_eoi_hits_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr0 && !bus_wdata[4] && !bus_wdata[3] && bus_wdata[7:5] == 3'd1)
        |=> ((svc_clr_o & ~$past(svc_vec)) == '0));

    assert_line_eoi_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr0 && !bus_wdata[4] && !bus_wdata[3] && bus_wdata[5] && bus_wdata[6])
        |=> (svc_clr_o == (N_LINES'(1) << $past(bus_wdata[2:0]))));

    assert_poll_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && s_q.poll && pend_valid)
        |=> (req_clr_o == (N_LINES'(1) << $past(pend_line)) && !s_q.poll));

    assert_mask_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr1 && !init_busy_o) |=> (mask_o == $past(N_LINES'(bus_wdata))));

    assert_bad_init_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr0 && bus_wdata[4] && (bus_wdata[3] || bus_wdata[1]))
        |=> (init_err_o && $stable(mask_o) && $stable(init_busy_o) && !ctl_reset_o));
endmodule

// File: tb/test_irq_cmd_decoder.sv
module test_irq_cmd_decoder;
    localparam int CLK_P = 10;

    // {op(1) addr(1) data(8) svc(8) sel(4) req(4) exp(8)}
    // op 0 = write then inspect sel, op 1 = read and inspect rdata
    // sel: 1 mask, 2 offset, 3 svc_clr, 4 rdata, 5 vec_base, 6 modes {busy,nested,aeoi,rot,smm}
    localparam logic [33:0] VEC [20] = '{
        {1'b0, 1'b0, 8'h11, 8'h00, 4'd6, 4'd1,  8'h10}, // R1 start, mode byte expected
        {1'b0, 1'b1, 8'h48, 8'h00, 4'd5, 4'd2,  8'h48}, // R2 base byte
        {1'b0, 1'b1, 8'h04, 8'h00, 4'd6, 4'd2,  8'h10}, // R2 discarded byte, still busy
        {1'b0, 1'b1, 8'h12, 8'h00, 4'd6, 4'd3,  8'h0C}, // R3 mode byte
        {1'b0, 1'b1, 8'hA5, 8'h00, 4'd1, 4'd11, 8'hA5}, // R11 mask load
        {1'b1, 1'b1, 8'h00, 8'h00, 4'd4, 4'd9,  8'hA5}, // R9 mask read
        {1'b1, 1'b0, 8'h00, 8'h00, 4'd4, 4'd9,  8'h5A}, // R9 request read
        {1'b0, 1'b0, 8'h0B, 8'h00, 4'd6, 4'd8,  8'h0C}, // R8 select in-service
        {1'b1, 1'b0, 8'h00, 8'h24, 4'd4, 4'd8,  8'h24}, // R8 in-service read
        {1'b0, 1'b0, 8'h20, 8'h24, 4'd3, 4'd4,  8'h04}, // R4 non-specific, offset 0
        {1'b0, 1'b0, 8'hA0, 8'h24, 4'd2, 4'd5,  8'h03}, // R5 rotate to 3
        {1'b0, 1'b0, 8'h20, 8'h24, 4'd3, 4'd4,  8'h20}, // R4 offset 3 picks line 5
        {1'b0, 1'b0, 8'h66, 8'h24, 4'd3, 4'd6,  8'h40}, // R6 specific line 6
        {1'b0, 1'b0, 8'hC1, 8'h24, 4'd2, 4'd6,  8'h02}, // R6 set priority
        {1'b0, 1'b0, 8'hE7, 8'h24, 4'd2, 4'd6,  8'h00}, // R6 specific rotate wraps
        {1'b0, 1'b0, 8'h80, 8'h00, 4'd6, 4'd7,  8'h0E}, // R7 rotate on
        {1'b0, 1'b0, 8'h68, 8'h00, 4'd6, 4'd8,  8'h0F}, // R8 special mask on
        {1'b0, 1'b0, 8'h00, 8'h00, 4'd6, 4'd7,  8'h0D}, // R7 rotate off
        {1'b0, 1'b0, 8'h08, 8'h00, 4'd6, 4'd8,  8'h0D}, // R8 no enables, nothing changes
        {1'b1, 1'b0, 8'h00, 8'h24, 4'd4, 4'd8,  8'h24}  // R8 select kept
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic [7:0] req_vec = 8'h5A, svc_vec = '0;
    logic       pend_valid = 1'b0;
    logic [2:0] pend_line = '0;
    logic [7:0] mask_o, vec_base_o, svc_clr_o, req_clr_o;
    logic [2:0] rot_base_o;
    logic       nested_mode_o, auto_eoi_o, rotate_aeoi_o, special_mask_o;
    logic       ctl_reset_o, init_busy_o, init_err_o;

    int n_chk = 0, n_bad = 0;
    logic done = 1'b0;

    irq_cmd_decoder i_irq_cmd_decoder (
        .clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata,
        .req_vec, .svc_vec, .pend_valid, .pend_line,
        .mask_o, .rot_base_o, .vec_base_o, .nested_mode_o, .auto_eoi_o,
        .rotate_aeoi_o, .special_mask_o, .svc_clr_o, .req_clr_o,
        .ctl_reset_o, .init_busy_o, .init_err_o
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] r);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #(CLK_P/4);
        r = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    function automatic logic [7:0] view(input logic [3:0] sel);
        case (sel)
            4'd1: return mask_o;
            4'd2: return {5'b0, rot_base_o};
            4'd3: return svc_clr_o;
            4'd5: return vec_base_o;
            4'd6: return {3'b0, init_busy_o, nested_mode_o, auto_eoi_o, rotate_aeoi_o, special_mask_o};
            default: return 8'h00;
        endcase
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // reset state, R9 and R12 outputs idle
        chk("R11 reset mask", mask_o, 8'h00);
        chk("R2 reset busy", {7'b0, init_busy_o}, 8'h00);
        chk("R12 reset err", {7'b0, init_err_o}, 8'h00);
        rd(1'b1, r);
        chk("R9 reset mask read", r, 8'h00);

        for (int i = 0; i < 20; i++) begin
            logic [33:0] v;
            string tag;
            v = VEC[i];
            svc_vec = v[23:16];
            tag = $sformatf("R%0d vec%0d", v[11:8], i);
            if (v[33]) begin
                rd(v[32], r);
                chk(tag, r, v[7:0]);
            end else begin
                wr(v[32], v[31:24]);
                chk(tag, view(v[15:12]), v[7:0]);
            end
        end

        // R10 poll with a pending line
        wr(1'b0, 8'h0C);
        pend_valid = 1'b1; pend_line = 3'd5;
        rd(1'b0, r);
        chk("R10 poll line", r, 8'h05);
        chk("R10 poll req clear", req_clr_o, 8'h20);
        chk("R10 poll svc clear", svc_clr_o, 8'h20);
        svc_vec = 8'h24;
        rd(1'b0, r);
        chk("R10 poll disarmed", r, 8'h24);
        // R10 poll with nothing pending
        wr(1'b0, 8'h0C);
        pend_valid = 1'b0;
        rd(1'b1, r);
        chk("R10 poll empty", r, 8'h07);
        chk("R10 poll empty no clear", req_clr_o, 8'h00);

        // R5 rotate EOI with nothing in service
        wr(1'b0, 8'hC3);
        chk("R6 set priority 4", {5'b0, rot_base_o}, 8'h04);
        svc_vec = 8'h00;
        wr(1'b0, 8'hA0);
        chk("R5 empty keeps offset", {5'b0, rot_base_o}, 8'h04);
        chk("R5 empty no clear", svc_clr_o, 8'h00);
        // R4 wrap past line 7 from offset 4
        svc_vec = 8'h09;
        wr(1'b0, 8'h20);
        chk("R4 wrap scan", svc_clr_o, 8'h01);

        // R12 unsupported start bytes
        wr(1'b0, 8'h1A);
        chk("R12 err", {7'b0, init_err_o}, 8'h01);
        chk("R12 mask kept", mask_o, 8'hA5);
        chk("R12 not busy", {7'b0, init_busy_o}, 8'h00);
        wr(1'b0, 8'h12);
        chk("R12 single err", {7'b0, init_err_o}, 8'h01);
        chk("R12 no reset", {7'b0, ctl_reset_o}, 8'h00);

        // R1/R2 start without mode byte
        wr(1'b0, 8'h10);
        chk("R1 reset pulse", {7'b0, ctl_reset_o}, 8'h01);
        chk("R1 mask cleared", mask_o, 8'h00);
        chk("R1 modes cleared", view(4'd6), 8'h10);
        wr(1'b1, 8'h20);
        chk("R2 base", vec_base_o, 8'h20);
        wr(1'b1, 8'h00);
        chk("R2 ends after two bytes", {7'b0, init_busy_o}, 8'h00);
        wr(1'b1, 8'h3C);
        chk("R11 mask after init", mask_o, 8'h3C);
        chk("R2 base kept", vec_base_o, 8'h20);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule